// File: doc/BRIEF.md
# Dual Parity-Checked Bus Transceiver

This block connects two byte-wide buses, an A side and a B side, through a set of lanes. Each lane carries eight data bits and one parity line that works in both directions. Each lane has its own pair of active-low output enables, which choose where its data goes. When a byte travels from A to B, the lane drives it onto B and drives a parity bit that makes the nine bits odd. When a byte travels from B to A, the lane drives it onto A, takes the parity line as an input and checks the nine bits for odd parity.

The result of each B-to-A check goes into a per-lane register on the rising clock edge. The register is read out as an active-low error flag. A per-lane active-low clear forces the flag to the no-error state at once, at any time. When a lane has both enables asserted, the data still moves from A to B, but the parity bit is inverted on purpose. Logic further down the bus can then be tested against a known parity error.

The pins of each bus are split into a separate input, output and output-enable. Pad-level tristate logic can therefore be placed outside the block. A global reset brings every flag up in the no-error state.

Top module: `ptx_dual_parity_xcvr`

## Requirements
- R1: With oeb_n=0 and oea_n=1 (forward mode), b_out equals a_in, b_oe=1 and a_oe=0.
- R2: In forward mode par_oe=1, and par_out is set so that b_out together with par_out holds an odd number of ones.
- R3: With oea_n=0 and oeb_n=1 (return mode), a_out equals b_in, a_oe=1, b_oe=0 and par_oe=0.
- R4: On a rising clock edge in return mode with clr_n high, err_n takes 1 if b_in together with par_in holds an odd number of ones, and 0 otherwise. The flag is not sticky.
- R5: clr_n=0 drives err_n to 1 without waiting for a clock edge. The clear also wins over a return-mode load on the same edge.
- R6: With oea_n=0 and oeb_n=0 (forced-error mode), b_out equals a_in, b_oe=1, par_oe=1 and a_oe=0. par_out is inverted, so b_out together with par_out holds an even number of ones.
- R7: With oea_n=1 and oeb_n=1 (isolated mode), a_oe, b_oe and par_oe are all 0, and a_out, b_out and par_out are all 0.
- R8: On a clock edge outside return mode, err_n keeps its value.
- R9: While rst_n is low, and after it is released, every err_n reads 1 until a return-mode check loads a result.
- R10: Each lane follows only its own enables, clear, data and parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error registers |
| rst_n | input | 1 | Global reset, active low; asserted asynchronously, released synchronously |
| clr_n | input | LANES | Per-lane clear of the error flag, active low |
| oea_n | input | LANES | Per-lane enable for driving A, active low |
| oeb_n | input | LANES | Per-lane enable for driving B, active low |
| a_in | input | LANES*DATA_W | A-bus pin inputs, lane i at bits [i*DATA_W +: DATA_W] |
| a_out | output | LANES*DATA_W | A-bus pin outputs |
| a_oe | output | LANES | Per-lane A-bus drive enable |
| b_in | input | LANES*DATA_W | B-bus pin inputs |
| b_out | output | LANES*DATA_W | B-bus pin outputs |
| b_oe | output | LANES | Per-lane B-bus drive enable |
| par_in | input | LANES | Parity pin inputs |
| par_out | output | LANES | Parity pin outputs |
| par_oe | output | LANES | Parity pin drive enable |
| err_n | output | LANES | Registered parity-error flag, active low |

## Verification
Bytes of all zeros and all ones are used because their parity bit is 1, the same as for any other even-weight byte. Single-bit and two-bit bytes then separate odd weight from even weight. In return mode, parity inputs are tried that both agree and disagree with the byte, so a correct check can be told from a flag stuck at one value. Random traffic is spread over all four enable pairs, with short clear pulses, and the two lanes are driven differently. This shows whether the flag holds outside return mode, whether a clear wins over a load on the same edge, and whether one lane's state ever leaks into the other.

// File: rtl/ptx_pkg.sv
`timescale 1ns/1ps
package ptx_pkg;
  typedef enum logic [1:0] {
    MODE_ISOLATE = 2'b00,
    MODE_FWD     = 2'b01,
    MODE_RET     = 2'b10,
    MODE_FORCE   = 2'b11
  } ptx_mode_e;

  function automatic ptx_mode_e decode_mode(input logic oea_n, input logic oeb_n);
    ptx_mode_e m;
    unique case ({oea_n, oeb_n})
      2'b10:   m = MODE_FWD;
      2'b01:   m = MODE_RET;
      2'b00:   m = MODE_FORCE;
      default: m = MODE_ISOLATE;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/ptx_rst_sync.sv
`timescale 1ns/1ps
module ptx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ptx_lane_path.sv
`timescale 1ns/1ps
module ptx_lane_path
  import ptx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              oea_n,
  input  logic              oeb_n,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              par_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  output logic [DATA_W-1:0] b_out,
  output logic              b_oe,
  output logic              par_out,
  output logic              par_oe,
  output logic              ret_mode,
  output logic              chk_ok
);
  ptx_mode_e mode;
  logic      par_gen;

  always_comb begin
    mode    = decode_mode(oea_n, oeb_n);
    par_gen = ~(^a_in);
    chk_ok  = ^{b_in, par_in};
    a_out   = '0;
    b_out   = '0;
    a_oe    = 1'b0;
    b_oe    = 1'b0;
    par_out = 1'b0;
    par_oe  = 1'b0;
    unique case (mode)
      MODE_FWD: begin
        b_out   = a_in;
        b_oe    = 1'b1;
        par_out = par_gen;
        par_oe  = 1'b1;
      end
      MODE_FORCE: begin
        b_out   = a_in;
        b_oe    = 1'b1;
        par_out = ~par_gen;
        par_oe  = 1'b1;
      end
      MODE_RET: begin
        a_out = b_in;
        a_oe  = 1'b1;
      end
      default: ;
    endcase
    ret_mode = (mode == MODE_RET);
  end
endmodule

// File: rtl/ptx_err_flag.sv
`timescale 1ns/1ps
module ptx_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic chk_ok,
  output logic err_n
);
  logic err_q;
  logic err_d;

  always_comb begin
    err_d = err_q;
    if (load_en) err_d = chk_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b1;
    else if (load_en) err_q <= err_d;
  end

  assign err_n = err_q;
endmodule

// File: rtl/ptx_dual_parity_xcvr.sv
`timescale 1ns/1ps
module ptx_dual_parity_xcvr #(
  parameter int LANES  = 2,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        clr_n,
  input  logic [LANES-1:0]        oea_n,
  input  logic [LANES-1:0]        oeb_n,
  input  logic [LANES*DATA_W-1:0] a_in,
  output logic [LANES*DATA_W-1:0] a_out,
  output logic [LANES-1:0]        a_oe,
  input  logic [LANES*DATA_W-1:0] b_in,
  output logic [LANES*DATA_W-1:0] b_out,
  output logic [LANES-1:0]        b_oe,
  input  logic [LANES-1:0]        par_in,
  output logic [LANES-1:0]        par_out,
  output logic [LANES-1:0]        par_oe,
  output logic [LANES-1:0]        err_n
);
  logic rst_sync_n;

  ptx_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic ret_mode;
    logic chk_ok;
    logic lane_rst_n;

    assign lane_rst_n = rst_sync_n & clr_n[i];

    ptx_lane_path #(.DATA_W(DATA_W)) i_path (
      .oea_n    (oea_n[i]),
      .oeb_n    (oeb_n[i]),
      .a_in     (a_in[i*DATA_W +: DATA_W]),
      .b_in     (b_in[i*DATA_W +: DATA_W]),
      .par_in   (par_in[i]),
      .a_out    (a_out[i*DATA_W +: DATA_W]),
      .a_oe     (a_oe[i]),
      .b_out    (b_out[i*DATA_W +: DATA_W]),
      .b_oe     (b_oe[i]),
      .par_out  (par_out[i]),
      .par_oe   (par_oe[i]),
      .ret_mode (ret_mode),
      .chk_ok   (chk_ok)
    );

    ptx_err_flag i_err (
      .clk     (clk),
      .rst_n   (lane_rst_n),
      .load_en (ret_mode),
      .chk_ok  (chk_ok),
      .err_n   (err_n[i])
    );
  end
endmodule

// File: rtl/ptx_checker.sv
`timescale 1ns/1ps
module ptx_checker #(
  parameter int LANES  = 2,
  parameter int DATA_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rst_sync_n,
  input logic [LANES-1:0]        clr_n,
  input logic [LANES-1:0]        oea_n,
  input logic [LANES-1:0]        oeb_n,
  input logic [LANES*DATA_W-1:0] a_in,
  input logic [LANES*DATA_W-1:0] b_in,
  input logic [LANES*DATA_W-1:0] b_out,
  input logic [LANES-1:0]        a_oe,
  input logic [LANES-1:0]        b_oe,
  input logic [LANES-1:0]        par_in,
  input logic [LANES-1:0]        par_out,
  input logic [LANES-1:0]        par_oe,
  input logic [LANES-1:0]        err_n
);
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R2
    a_r2_fwd_odd: assert property (@(posedge clk) disable iff (!rst_n)
      (oea_n[i] && !oeb_n[i]) |-> (par_oe[i] && (^{b_out[i*DATA_W +: DATA_W], par_out[i]})));
    // R6
    a_r6_force_even: assert property (@(posedge clk) disable iff (!rst_n)
      (!oea_n[i] && !oeb_n[i]) |-> (par_oe[i] && !(^{b_out[i*DATA_W +: DATA_W], par_out[i]})));
    // R7
    a_r7_isolate: assert property (@(posedge clk) disable iff (!rst_n)
      (oea_n[i] && oeb_n[i]) |-> (!a_oe[i] && !b_oe[i] && !par_oe[i]));
    // R4
    a_r4_ret_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (clr_n[i] && $past(clr_n[i]) && $past(rst_sync_n) && $past(!oea_n[i] && oeb_n[i]))
      |-> (err_n[i] == $past(^{b_in[i*DATA_W +: DATA_W], par_in[i]})));
    // R5
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n[i] |-> err_n[i]);
    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (clr_n[i] && $past(clr_n[i]) && $past(rst_sync_n) && !$past(!oea_n[i] && oeb_n[i]))
      |-> $stable(err_n[i]));
    // R3
    a_r3_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_oe[i] && (b_oe[i] || par_oe[i])));
  end
endmodule

bind ptx_dual_parity_xcvr ptx_checker #(.LANES(LANES), .DATA_W(DATA_W)) i_ptx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .clr_n      (clr_n),
  .oea_n      (oea_n),
  .oeb_n      (oeb_n),
  .a_in       (a_in),
  .b_in       (b_in),
  .b_out      (b_out),
  .a_oe       (a_oe),
  .b_oe       (b_oe),
  .par_in     (par_in),
  .par_out    (par_out),
  .par_oe     (par_oe),
  .err_n      (err_n)
);

// File: tb/test_ptx_dual_parity_xcvr.sv
`timescale 1ns/1ps
module test_ptx_dual_parity_xcvr;
  localparam int L = 2;
  localparam int W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [L-1:0]     clr_n, oea_n, oeb_n, par_in;
  logic [L*W-1:0]   a_in, b_in;
  logic [L*W-1:0]   a_out, b_out;
  logic [L-1:0]     a_oe, b_oe, par_out, par_oe, err_n;

  int checks = 0;
  int fails  = 0;
  logic [L-1:0] exp_err;

  always #2 clk = ~clk;

  ptx_dual_parity_xcvr #(.LANES(L), .DATA_W(W)) i_ptx_dual_parity_xcvr (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .oea_n(oea_n), .oeb_n(oeb_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out),
    .b_oe(b_oe), .par_in(par_in), .par_out(par_out), .par_oe(par_oe), .err_n(err_n)
  );

  function automatic int ones(input logic [W-1:0] v, input logic p);
    int n = int'(p);
    for (int k = 0; k < W; k++) n += int'(v[k]);
    return n;
  endfunction

  task automatic chk(input string req, input int lane, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s lane %0d: actual %0h expected %0h", req, lane, act, exp);
    end
  endtask

  // Inputs are already applied just after a falling edge.
  task automatic cycle();
    #1;
    for (int i = 0; i < L; i++) begin
      logic [W-1:0] a = a_in[i*W +: W];
      logic [W-1:0] b = b_in[i*W +: W];
      logic [W-1:0] ao = a_out[i*W +: W];
      logic [W-1:0] bo = b_out[i*W +: W];
      case ({oea_n[i], oeb_n[i]})
        2'b10: begin
          chk("R1", i, {bo, b_oe[i], a_oe[i]}, {a, 1'b1, 1'b0});
          chk("R2", i, {par_oe[i], 31'(ones(bo, par_out[i]) % 2)}, {1'b1, 31'd1});
        end
        2'b01: chk("R3", i, {ao, a_oe[i], b_oe[i], par_oe[i]}, {b, 1'b1, 1'b0, 1'b0});
        2'b00: begin
          chk("R6", i, {bo, b_oe[i], a_oe[i], par_oe[i]}, {a, 1'b1, 1'b0, 1'b1});
          chk("R6", i, 32'(ones(bo, par_out[i]) % 2), 32'd0);
        end
        default: chk("R7", i, {ao, bo, a_oe[i], b_oe[i], par_oe[i], par_out[i]}, '0);
      endcase
      if (!clr_n[i]) begin
        exp_err[i] = 1'b1;
        chk("R5", i, err_n[i], 1'b1);
      end else if (!oea_n[i] && oeb_n[i]) begin
        exp_err[i] = (ones(b, par_in[i]) % 2) == 1;
      end
    end
    @(negedge clk);
    for (int i = 0; i < L; i++) begin
      if (!clr_n[i])                    chk("R5", i, err_n[i], exp_err[i]);
      else if (!oea_n[i] && oeb_n[i])   chk("R4", i, err_n[i], exp_err[i]);
      else                              chk("R8", i, err_n[i], exp_err[i]);
    end
  endtask

  task automatic drive(input int lane, input logic oa, input logic ob, input logic cl,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic p);
    oea_n[lane] = oa; oeb_n[lane] = ob; clr_n[lane] = cl;
    a_in[lane*W +: W] = a; b_in[lane*W +: W] = b; par_in[lane] = p;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; clr_n = '1; oea_n = '1; oeb_n = '1; par_in = '0;
    a_in = '0; b_in = '0; exp_err = '1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < L; i++) chk("R9", i, err_n[i], 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < L; i++) chk("R9", i, err_n[i], 1'b1);

    // Directed forward and forced-error bytes
    drive(0, 1, 0, 1, 8'h00, 8'h00, 0); drive(1, 0, 0, 1, 8'hFF, 8'h00, 0); cycle();
    drive(0, 1, 0, 1, 8'h01, 8'h00, 0); drive(1, 0, 0, 1, 8'h03, 8'h00, 0); cycle();
    // Return mode: good, then bad parity; lanes differ (R10)
    drive(0, 0, 1, 1, 8'h00, 8'h01, 0); drive(1, 0, 1, 1, 8'h00, 8'h03, 0); cycle();
    drive(0, 0, 1, 1, 8'h00, 8'h03, 0); drive(1, 0, 1, 1, 8'h00, 8'h03, 1); cycle();
    // Hold outside return mode (R8) with bad parity on the pins
    drive(0, 1, 1, 1, 8'h00, 8'h00, 0); drive(1, 1, 0, 1, 8'h00, 8'h00, 0); cycle();
    // Clear beats a failing load on the same edge (R5)
    drive(0, 0, 1, 0, 8'h00, 8'h00, 0); drive(1, 0, 1, 1, 8'h00, 8'hFF, 0); cycle();
    drive(0, 0, 1, 1, 8'h00, 8'h07, 1); drive(1, 0, 1, 1, 8'h00, 8'hFF, 1); cycle();

    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < L; i++)
        drive(i, 1'($urandom), 1'($urandom), ($urandom % 8) != 0,
              8'($urandom), 8'($urandom), 1'($urandom));
      cycle();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule